// File: doc/BRIEF.md
# I2C Byte-Addressed Serial Memory Slave

This block puts a byte-wide memory array behind a two-wire serial bus as a slave. It samples the clock line (SCL) and the data line (SDA) with the system clock and finds start and stop conditions. It then takes in a device byte and answers only when that byte carries its fixed type code and the three select bits strapped on its pins. A write command loads a two-byte word address, high byte first, into an internal pointer and stores any data bytes that follow. A read command sends bytes from the pointer for as long as the master acknowledges each one.

A random read is a write command that carries only the word address, followed by a repeated start and a read command. A read command sent on its own reads from wherever the pointer was left. SDA is never driven high: the block only asserts a pull-low enable, and the pad or board combines it with the master's open-drain drive. The array holds 2^ADDR_W bytes, 2048 with the default parameters. It is inferred as synchronous block RAM with one write port and one read port.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: The block ignores bus activity until the first start condition (SDA falls while SCL is high). Bytes clocked before any start get no acknowledge.
- R2: A device byte whose bits 7..4 are 1010 and whose bits 3..1 equal `dev_sel_i[2:0]` is acknowledged: `sda_pull_o` is 1 (SDA low) during the 9th SCL clock. The pull only rises while SCL is low.
- R3: A device byte with a wrong type code or wrong select bits gets no acknowledge. All bytes after it, up to the next start, are ignored: none is acknowledged and the memory is not written.
- R4: In a write command (device byte bit 0 = 0), the block acknowledges a high address byte, a low address byte and any number of data bytes. Bits sent MSB first form the address {high[ADDR_W-9:0], low}; the upper high-byte bits are ignored.
- R5: Each data byte written is stored at the pointer, and the pointer then steps by one, wrapping from 2^ADDR_W-1 to 0.
- R6: A random read returns the byte stored at the loaded address, driven MSB first. Each bit is set up while SCL is low and held while SCL is high.
- R7: In a read command (bit 0 = 1), an acknowledge (SDA low) from the master on the 9th clock makes the block send the byte at the next address, wrapping from the last address to 0.
- R8: A master NACK (SDA high on the 9th clock) ends the read. The block releases SDA and drives nothing until a new start.
- R9: A read command without a preceding address phase starts at the pointer left by the previous access, which is one past the last byte read or written.
- R10: A stop condition (SDA rises while SCL is high) ends the command. Bytes clocked after it without a new start are not acknowledged.
- R11: While `rst` is high, and after it falls, `sda_pull_o` is 0.
- R12: A start in the middle of a byte discards the partial bits and returns the block to device-byte reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must be much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level as seen on the bus |
| dev_sel_i | input | 3 | Pin-strapped device select bits |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The main function is driven with write commands whose addresses cross an interior boundary and the top of the array, so a pointer that fails to step or to wrap stores bytes in the wrong place. Random reads, current-address reads and sequential reads with master ACK then NACK each reach the same stored bytes by a different path. This separates the address loading, the carried pointer and the read-ahead stepping. Device bytes with a wrong select field and with a wrong type code, followed by would-be write data, show that a rejected command leaves the memory untouched. Bytes sent with no start, after a stop, after a NACK, and across a start placed mid-byte check that the framing logic, not a byte count, decides when the block listens.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WR,
    ST_RD
  } slv_state_t;

  localparam logic [3:0] DEV_CODE = 4'b1010;
  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/i2cs_line_sampler.sv
module i2cs_line_sampler #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sh;
  logic [SYNC_STAGES-1:0] sda_sh;
  logic                   scl_p;
  logic                   sda_p;

  // Synchronizer chains; the bus idles high, so reset to 1.
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) begin
        scl_sh[g] <= 1'b1;
        sda_sh[g] <= 1'b1;
      end else if (g == 0) begin
        scl_sh[g] <= scl_i;
        sda_sh[g] <= sda_i;
      end else begin
        scl_sh[g] <= scl_sh[(g == 0) ? 0 : g-1];
        sda_sh[g] <= sda_sh[(g == 0) ? 0 : g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_sh[SYNC_STAGES-1];
      sda_p <= sda_sh[SYNC_STAGES-1];
    end
  end

  assign scl_lvl   = scl_sh[SYNC_STAGES-1];
  assign sda_lvl   = sda_sh[SYNC_STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_p;
  assign scl_fall  = ~scl_lvl & scl_p;
  assign start_det = scl_lvl & scl_p & sda_p & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_p & ~sda_p & sda_lvl;
endmodule

// File: rtl/i2cs_mem.sv
module i2cs_mem #(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
  import i2cs_pkg::*;
#(
  parameter int unsigned AW = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        dev_sel,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic [AW-1:0]     ptr,
  output logic              sda_pull,
  output slv_state_t        state
);
  localparam int unsigned HI_W = AW - BYTE_W;
  localparam logic [3:0]  LAST_BIT = 4'(BYTE_W);

  logic [3:0]        bit_cnt;
  logic              in_ack;
  logic              rw;
  logic              m_ack;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] tx;
  logic [HI_W-1:0]   hi;
  logic              dev_match;

  assign dev_match = (shreg[7:4] == DEV_CODE) && (shreg[3:1] == dev_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      in_ack    <= 1'b0;
      rw        <= 1'b0;
      m_ack     <= 1'b0;
      shreg     <= '0;
      tx        <= '0;
      hi        <= '0;
      ptr       <= '0;
      sda_pull  <= 1'b0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (start_det) begin
        state    <= ST_DEV;
        bit_cnt  <= '0;
        in_ack   <= 1'b0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        bit_cnt  <= '0;
        in_ack   <= 1'b0;
        sda_pull <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (scl_rise) begin
          if (in_ack) begin
            m_ack <= ~sda_lvl;
          end else begin
            shreg <= {shreg[BYTE_W-2:0], sda_lvl};
            if (bit_cnt < LAST_BIT) bit_cnt <= bit_cnt + 4'd1;
          end
        end else if (scl_fall) begin
          if (in_ack) begin
            // Falling edge that closes the acknowledge clock.
            in_ack   <= 1'b0;
            bit_cnt  <= '0;
            sda_pull <= 1'b0;
            unique case (state)
              ST_DEV: begin
                if (rw) begin
                  state    <= ST_RD;
                  tx       <= mem_rdata;
                  sda_pull <= ~mem_rdata[BYTE_W-1];
                  ptr      <= ptr + 1'b1;
                end else begin
                  state <= ST_AHI;
                end
              end
              ST_AHI: state <= ST_ALO;
              ST_ALO: state <= ST_WR;
              ST_WR:  state <= ST_WR;
              ST_RD: begin
                if (m_ack) begin
                  tx       <= mem_rdata;
                  sda_pull <= ~mem_rdata[BYTE_W-1];
                  ptr      <= ptr + 1'b1;
                end else begin
                  state <= ST_IDLE;
                end
              end
              default: state <= ST_IDLE;
            endcase
          end else if (bit_cnt == LAST_BIT) begin
            // Falling edge after the 8th bit: open the acknowledge clock.
            in_ack <= 1'b1;
            unique case (state)
              ST_DEV: begin
                if (dev_match) begin
                  sda_pull <= 1'b1;
                  rw       <= shreg[0];
                end else begin
                  state <= ST_IDLE;
                end
              end
              ST_AHI: begin
                hi       <= shreg[HI_W-1:0];
                sda_pull <= 1'b1;
              end
              ST_ALO: begin
                ptr      <= {hi, shreg};
                sda_pull <= 1'b1;
              end
              ST_WR: begin
                mem_we    <= 1'b1;
                mem_waddr <= ptr;
                mem_wdata <= shreg;
                ptr       <= ptr + 1'b1;
                sda_pull  <= 1'b1;
              end
              ST_RD:   sda_pull <= 1'b0;
              default: sda_pull <= 1'b0;
            endcase
          end else if (state == ST_RD) begin
            tx       <= {tx[BYTE_W-2:0], 1'b0};
            sda_pull <= ~tx[BYTE_W-2];
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import i2cs_pkg::*;
#(
  parameter int unsigned ADDR_W      = 11,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] dev_sel_i,
  output logic       sda_pull_o
);
  logic              scl_lvl;
  logic              sda_lvl;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [ADDR_W-1:0] ptr;
  logic [BYTE_W-1:0] mem_wdata;
  logic [BYTE_W-1:0] mem_rdata;
  slv_state_t        state;

  i2cs_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2cs_ctrl #(.AW(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .dev_sel   (dev_sel_i),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .mem_rdata (mem_rdata),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .ptr       (ptr),
    .sda_pull  (sda_pull_o),
    .state     (state)
  );

  i2cs_mem #(.AW(ADDR_W), .DW(BYTE_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (ptr),
    .rdata (mem_rdata)
  );
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker
  import i2cs_pkg::*;
#(
  parameter int unsigned AW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          sda_pull_o,
  input logic          scl_lvl,
  input logic          start_det,
  input logic          stop_det,
  input slv_state_t    state,
  input logic          mem_we,
  input logic [AW-1:0] mem_waddr,
  input logic [AW-1:0] ptr
);
  logic rst_q = 1'b0;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q) begin
      a_r11_released_in_reset: assert (!sda_pull_o)
        else $error("R11: pull active right after reset");
    end
  end

  a_r2_pull_on_scl_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull_o) |-> !$past(scl_lvl))
    else $error("R2: SDA pulled while SCL high");

  a_r8_idle_no_pull: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_pull_o)
    else $error("R8: pull active while idle");

  a_r12_start_to_dev: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == ST_DEV))
    else $error("R12: start did not return to device byte");

  a_r10_stop_to_idle: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (state == ST_IDLE))
    else $error("R10: stop did not end command");

  a_r5_ptr_step: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (ptr == AW'(mem_waddr + 1'b1)))
    else $error("R5: pointer did not step after write");
endmodule

bind i2c_eeprom_slave i2cs_checker #(.AW(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sda_pull_o (sda_pull_o),
  .scl_lvl    (scl_lvl),
  .start_det  (start_det),
  .stop_det   (stop_det),
  .state      (state),
  .mem_we     (mem_we),
  .mem_waddr  (mem_waddr),
  .ptr        (ptr)
);

// File: tb/i2c_eeprom_slave_test.sv
`timescale 1ns/1ps
module i2c_eeprom_slave_test;
  localparam int Q = 10;   // clk cycles per quarter SCL period

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] dev_sel = 3'b101;
  logic       sda_pull_o;
  logic       sda_line;

  assign sda_line = sda_m & ~sda_pull_o;

  always #2.5 clk = ~clk;   // 200 MHz

  i2c_eeprom_slave uut (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl),
    .sda_i      (sda_line),
    .dev_sel_i  (dev_sel),
    .sda_pull_o (sda_pull_o)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  int    exp_q[$];
  string tag_q[$];
  int    act_q[$];

  localparam logic [7:0] WR_B = 8'hAA;  // 1010 101 0
  localparam logic [7:0] RD_B = 8'hAB;  // 1010 101 1

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard driver side: expected items
  task automatic expect_item(input string tag, input int v);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // Monitor: pops expected and observed items in order
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0 && exp_q.size() > 0) begin
        automatic int    a = act_q.pop_front();
        automatic int    e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, a, e);
      end
    end
  end

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic bits_out(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(Q);
      scl = 1'b1;   tick(2*Q);
      scl = 1'b0;   tick(Q);
    end
  endtask

  // Sends a byte; ack item 0 = acknowledged (SDA low), 1 = not
  task automatic send_byte(input logic [7:0] b, input int exp_nack, input string tag);
    expect_item(tag, exp_nack);
    bits_out(b, 8);
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    act_q.push_back(int'(sda_line));
    tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic recv_byte(input logic [7:0] expv, input logic nack, input string tag);
    logic [7:0] b;
    expect_item(tag, int'(expv));
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl = 1'b1; tick(Q);
      b[i] = sda_line;
      tick(Q);
      scl = 1'b0; tick(Q);
    end
    act_q.push_back(int'(b));
    sda_m = nack; tick(Q);
    scl = 1'b1;   tick(2*Q);
    scl = 1'b0;   tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic set_addr(input logic [7:0] h, input logic [7:0] l, input string tag);
    bus_start();
    send_byte(WR_B, 0, {tag, " dev ack"});
    send_byte(h, 0, {tag, " addr hi ack"});
    send_byte(l, 0, {tag, " addr lo ack"});
  endtask

  initial begin
    tick(5);
    rst = 1'b0;
    tick(3);
    check("R11 pull released after reset", int'(sda_pull_o), 0);

    // R1: no start seen yet
    send_byte(WR_B, 1, "R1 byte before any start");

    // R4/R5: write 0x1FE..0x201, upper high-byte bits ignored (0xE1 -> 1)
    set_addr(8'hE1, 8'hFE, "R4");
    send_byte(8'h11, 0, "R4 data0 ack");
    send_byte(8'h22, 0, "R4 data1 ack");
    send_byte(8'h33, 0, "R5 data2 ack");
    send_byte(8'h66, 0, "R5 data3 ack");
    bus_stop();

    // R5: write across top of array
    set_addr(8'h07, 8'hFF, "R5 wrap");
    send_byte(8'h44, 0, "R5 data at last addr");
    send_byte(8'h55, 0, "R5 data at addr 0");
    bus_stop();

    // R6/R7: random read, sequential continuation, NACK end
    set_addr(8'h01, 8'hFE, "R6");
    bus_start();
    send_byte(RD_B, 0, "R6 read dev ack");
    recv_byte(8'h11, 1'b0, "R6 random read byte");
    recv_byte(8'h22, 1'b0, "R7 sequential byte 1");
    recv_byte(8'h33, 1'b1, "R7 sequential byte 2");
    bus_stop();

    // R9: current-address read continues at 0x201
    bus_start();
    send_byte(RD_B, 0, "R9 dev ack");
    recv_byte(8'h66, 1'b1, "R9 current address byte");
    bus_stop();

    // R7 wrap and R8 release after NACK
    set_addr(8'h07, 8'hFF, "R7 wrap");
    bus_start();
    send_byte(RD_B, 0, "R7 wrap dev ack");
    recv_byte(8'h44, 1'b0, "R7 last addr byte");
    recv_byte(8'h55, 1'b1, "R7 wrapped addr 0 byte");
    recv_byte(8'hFF, 1'b1, "R8 bus released after NACK");
    bus_stop();

    // R3: wrong select bits, then would-be write data
    bus_start();
    send_byte(8'hA2, 1, "R3 wrong select nack");
    send_byte(8'h07, 1, "R3 ignored hi");
    send_byte(8'hFF, 1, "R3 ignored lo");
    send_byte(8'h99, 1, "R3 ignored data");
    bus_stop();
    bus_start();
    send_byte(8'hBA, 1, "R3 wrong type code nack");
    bus_stop();
    set_addr(8'h07, 8'hFF, "R3 verify");
    bus_start();
    send_byte(RD_B, 0, "R3 verify dev ack");
    recv_byte(8'h44, 1'b1, "R3 memory untouched");
    bus_stop();

    // R10: after stop, no start
    send_byte(WR_B, 1, "R10 byte after stop");

    // R12: start mid-byte then read at pointer (addr 0 holds 0x55)
    bus_start();
    bits_out(8'hF0, 4);
    bus_start();
    send_byte(RD_B, 0, "R12 dev ack after mid-byte start");
    recv_byte(8'h55, 1'b1, "R12 read after restart");
    bus_stop();

    tick(20);
    check("scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule